// File: doc/BRIEF.md
# Fractional Audio Clock Generator

This block derives the two clocks that one direction of an I2S audio port needs: a master clock and a serial bit clock. Both come from a single peripheral clock. A fractional stage scales the input rate by X/Y and then halves it. An integer stage then divides the master clock by a programmable count plus one to produce the bit clock. As a sizing example, 48 kHz stereo audio with 16-bit samples needs a bit clock of 48000 × 16 × 2 = 1.536 MHz.

The whole block runs on the input clock. The master clock and the bit clock are registered levels, so no internal flop is clocked by a derived clock. A companion one-cycle strobe marks each bit-clock edge, and downstream logic uses it as a clock enable. When any setting changes, the internal phase is restarted so that no shortened output pulse is produced.

Top module: `audclk_gen`

## Requirements
- R1: After reset, mclkOut, bclkOut and bclkEdge are all 0, and with all settings at zero they stay at 0.
- R2: With 0 < xNum ≤ yDen, the phase accumulator starts at 0 and adds xNum on every cycle. When the sum reaches yDen or more, yDen is subtracted and the master clock toggles. This gives exactly xNum toggles in every yDen cycles, so mclkOut has the frequency clk × X / Y / 2.
- R3: While xNum or yDen is zero, the outputs mclkOut and bclkOut hold their levels and bclkEdge stays 0.
- R4: When xNum > yDen (both nonzero), the rate saturates and mclkOut toggles on every cycle.
- R5: The bclkOut output toggles on every (bitDiv+1)-th master-clock toggle, counted from a restart. With bitDiv = 0, bclkOut follows mclkOut.
- R6: The bclkEdge output is 1 for exactly the cycles in which bclkOut shows a new level after a toggle. Each such cycle is also a cycle in which mclkOut changed.
- R7: A change in any of xNum, yDen or bitDiv restarts the block. In the next cycle mclkOut, bclkOut and bclkEdge are 0, and the accumulator and the divider count restart from zero.
- R8: All outputs change only on the rising edge of clk. An output toggle becomes visible one cycle after the input cycle that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| xNum | input | 8 | Rate numerator X |
| yDen | input | 8 | Rate denominator Y |
| bitDiv | input | 6 | Bit-clock divide value (divides by value + 1) |
| mclkOut | output | 1 | Master clock level |
| bclkOut | output | 1 | Bit clock level |
| bclkEdge | output | 1 | One-cycle strobe on each bit-clock toggle |

## Verification
A wrong accumulator residue does not appear at once. It shifts the position of a master-clock toggle, which becomes visible in the first cycle where the wrongly computed sum crosses Y. That cycle is at most Y cycles away. The bench compares every output on every cycle with a behavioural model, so the first misplaced toggle is reported in the cycle it happens. A wrong bit-divider count appears within bitDiv+1 master toggles. A missed restart shows as a non-zero output level in the cycle right after a setting changes.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  // Strobes passed from the rate control to the clock datapath.
  typedef struct packed {
    logic clear;     // restart all phase state
    logic mclkTick;  // master clock toggles at the end of this cycle
  } clkStrobe_t;
endpackage

// File: rtl/audclk_ctrl.sv
module audclk_ctrl
  import audclk_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FRAC_W-1:0] xNum,
  input  logic [FRAC_W-1:0] yDen,
  input  logic [DIV_W-1:0]  bitDiv,
  output clkStrobe_t        strobes
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] xQ, yQ, acc, accNext;
  logic [DIV_W-1:0]  divQ;
  logic [SUM_W-1:0]  sum;
  logic cfgChange, running, saturated, reached, tick;

  always_comb begin
    cfgChange = (xNum != xQ) || (yDen != yQ) || (bitDiv != divQ);
    running   = (xNum != '0) && (yDen != '0);
    saturated = xNum >= yDen;
    sum       = {1'b0, acc} + {1'b0, xNum};
    reached   = sum >= {1'b0, yDen};
    tick      = !cfgChange && running && (saturated || reached);
    accNext   = acc;
    if (cfgChange || saturated)
      accNext = '0;
    else if (running)
      accNext = reached ? FRAC_W'(sum - {1'b0, yDen}) : sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xQ   <= '0;
      yQ   <= '0;
      divQ <= '0;
      acc  <= '0;
    end else begin
      xQ   <= xNum;
      yQ   <= yDen;
      divQ <= bitDiv;
      acc  <= accNext;
    end
  end

  assign strobes.clear    = cfgChange;
  assign strobes.mclkTick = tick;
endmodule

// File: rtl/audclk_dpath.sv
module audclk_dpath
  import audclk_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  clkStrobe_t       strobes,
  input  logic [DIV_W-1:0] bitDiv,
  output logic             mclkOut,
  output logic             bclkOut,
  output logic             bclkEdge
);
  logic [DIV_W-1:0] divCnt;
  logic divWrap;

  assign divWrap = (divCnt == bitDiv);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      mclkOut  <= 1'b0;
      bclkOut  <= 1'b0;
      bclkEdge <= 1'b0;
      divCnt   <= '0;
    end else begin
      bclkEdge <= 1'b0;
      if (strobes.mclkTick) begin
        mclkOut <= !mclkOut;
        if (divWrap) begin
          divCnt   <= '0;
          bclkOut  <= !bclkOut;
          bclkEdge <= 1'b1;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
  import audclk_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FRAC_W-1:0] xNum,
  input  logic [FRAC_W-1:0] yDen,
  input  logic [DIV_W-1:0]  bitDiv,
  output logic              mclkOut,
  output logic              bclkOut,
  output logic              bclkEdge
);
  clkStrobe_t strobes;

  audclk_ctrl #(.FRAC_W(FRAC_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .xNum(xNum), .yDen(yDen), .bitDiv(bitDiv),
    .strobes(strobes)
  );

  audclk_dpath #(.DIV_W(DIV_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitDiv(bitDiv),
    .mclkOut(mclkOut), .bclkOut(bclkOut), .bclkEdge(bclkEdge)
  );
endmodule

// File: rtl/audclk_checker.sv
module audclk_checker #(
  parameter int FRAC_W = 8,
  parameter int DIV_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [FRAC_W-1:0] xNum,
  input logic [FRAC_W-1:0] yDen,
  input logic [DIV_W-1:0]  bitDiv,
  input logic              mclkOut,
  input logic              bclkOut,
  input logic              bclkEdge
);
  logic pastValid;
  logic [2*FRAC_W+DIV_W-1:0] cfg;
  assign cfg = {xNum, yDen, bitDiv};

  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && (xNum == '0 || yDen == '0) && cfg == $past(cfg))
      |=> ($stable(mclkOut) && $stable(bclkOut) && !bclkEdge));

  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && xNum != '0 && yDen != '0 && xNum > yDen && cfg == $past(cfg))
      |=> (mclkOut != $past(mclkOut)));

  assert_edge_marks_bclk_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && bclkEdge) |-> (bclkOut != $past(bclkOut)));

  assert_edge_with_mclk_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && bclkEdge) |-> (mclkOut != $past(mclkOut)));

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && cfg != $past(cfg)) |=> (!mclkOut && !bclkOut && !bclkEdge));
endmodule

bind audclk_gen audclk_checker #(.FRAC_W(FRAC_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .xNum(xNum), .yDen(yDen), .bitDiv(bitDiv),
  .mclkOut(mclkOut), .bclkOut(bclkOut), .bclkEdge(bclkEdge)
);

// File: tb/audclk_gen_tb.sv
module audclk_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] xNum = '0, yDen = '0;
  logic [5:0] bitDiv = '0;
  logic mclkOut, bclkOut, bclkEdge;

  int checkCount = 0;
  int errCount = 0;
  string curReq = "R1";
  bit modelOn = 0;

  // behavioural model state
  int mAcc = 0, mCnt = 0, mPrev = 0;
  bit mM = 0, mB = 0, mE = 0;

  audclk_gen u_dut (
    .clk(clk), .rstN(rstN), .xNum(xNum), .yDen(yDen), .bitDiv(bitDiv),
    .mclkOut(mclkOut), .bclkOut(bclkOut), .bclkEdge(bclkEdge)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int cfg;
    bit tick;
    cfg = {xNum, yDen, bitDiv};
    if (!rstN) begin
      mAcc = 0; mCnt = 0; mM = 0; mB = 0; mE = 0; mPrev = 0;
    end else begin
      if (cfg != mPrev) begin
        mAcc = 0; mCnt = 0; mM = 0; mB = 0; mE = 0;
      end else begin
        mE = 0;
        tick = 0;
        if (xNum != 0 && yDen != 0) begin
          if (xNum >= yDen) tick = 1;
          else begin
            mAcc += xNum;
            if (mAcc >= yDen) begin mAcc -= yDen; tick = 1; end
          end
        end
        if (tick) begin
          mM = !mM;
          if (mCnt == bitDiv) begin mCnt = 0; mB = !mB; mE = 1; end
          else mCnt++;
        end
      end
      mPrev = cfg;
    end
  end

  // per-cycle comparison, away from the active edge (R8)
  always @(negedge clk) begin
    if (modelOn) begin
      chk(mclkOut == mM, {curReq, "/R8 mclk"}, mclkOut, mM);
      chk(bclkOut == mB, {curReq, "/R5 bclk"}, bclkOut, mB);
      chk(bclkEdge == mE, {curReq, "/R6 edge"}, bclkEdge, mE);
    end
  end

  task automatic setCfg(input int x, input int y, input int d, input string req);
    @(negedge clk);
    xNum = 8'(x); yDen = 8'(y); bitDiv = 6'(d); curReq = req;
  endtask

  // R2: count master toggles over a window after a restart
  task automatic countWindow(input int x, input int y, input int cycles);
    int toggles = 0;
    bit prev;
    setCfg(x, y, 0, "R2");
    @(negedge clk);
    chk(mclkOut == 0 && bclkOut == 0 && bclkEdge == 0, "R7 restart", mclkOut, 0);
    prev = mclkOut;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (mclkOut != prev) toggles++;
      prev = mclkOut;
    end
    chk(toggles == cycles * x / y, "R2 toggle count", toggles, cycles * x / y);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mclkOut == 0 && bclkOut == 0 && bclkEdge == 0, "R1 reset", mclkOut, 0);
    rstN = 1'b1;
    modelOn = 1;
    repeat (20) @(negedge clk);
    chk(mclkOut == 0 && bclkOut == 0, "R1 idle after reset", bclkOut, 0);

    setCfg(1, 4, 0, "R5"); repeat (40) @(negedge clk);
    setCfg(3, 8, 2, "R2"); repeat (120) @(negedge clk);
    setCfg(5, 3, 1, "R4"); repeat (30) @(negedge clk);
    setCfg(7, 7, 3, "R4"); repeat (30) @(negedge clk);
    setCfg(0, 5, 1, "R3"); repeat (20) @(negedge clk);
    setCfg(3, 7, 0, "R2"); repeat (17) @(negedge clk);
    setCfg(3, 0, 0, "R3"); repeat (20) @(negedge clk);
    setCfg(255, 255, 63, "R5"); repeat (300) @(negedge clk);
    setCfg(200, 251, 5, "R2"); repeat (400) @(negedge clk);
    setCfg(200, 251, 6, "R7"); repeat (30) @(negedge clk);
    countWindow(3, 8, 80);
    countWindow(13, 50, 200);
    countWindow(1, 255, 510);
    setCfg(2, 9, 1, "R7"); repeat (11) @(negedge clk);
    setCfg(2, 9, 1, "R7"); repeat (60) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checkCount, errCount);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checkCount++;
    errCount++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checkCount, errCount);
    $finish;
  end
endmodule